// File: doc/BRIEF.md
# Triggered Six-Bit Pattern Output Port

This block drives a six-pin output pattern that changes only when a trigger event arrives. Software stages the next pattern in two buffer registers: a low buffer for pins 3..0 and a high buffer for pins 5..4. On a selected trigger the staged values are copied into an output latch, so every pin of a transferred group changes in the same clock cycle. A per-pin select register decides which pins show latched data. A control register holds the output enable and the trigger setup.

The trigger setup picks one of three behaviours. In whole-pattern mode one internal pulse loads all six bits. In split mode a second internal pulse loads the high pair on its own. In external mode a chosen edge (rising or falling) of an external trigger line loads all six bits. The trigger setup can only be changed while output is disabled. After any disable, both buffers must be written again before the pins may show data.

Top module: `trig_outport`

## Requirements
- R1: After reset the buffers, output latch, select register and control register are all 0, every register reads 0 and all six pins are 0.
- R2: While the enable bit (control bit 7) is 0, all six pins are 0 whatever the select register and latch hold.
- R3: While enabled and no rewrite is pending, pin i equals latch bit i ANDed with select bit i (select register address 2, bits 5..0). Pins that are not selected drive 0.
- R4: The control register is at address 3. Its setup bits are bit 0 (external edge, 1 = falling), bit 1 (split mode) and bit 2 (external trigger). These bits take a written value only if the enable bit was 0 before the write, otherwise the write leaves them unchanged. The enable bit is always written.
- R5: The high buffer (address 1) stores data bits 1..0 only, and its bits 7..2, including 7 and 6, always read 0.
- R6: A 1-to-0 change of the enable bit sets a rewrite condition that holds all pins at 0. The condition clears only after both the low buffer (address 0) and the high buffer have been written.
- R7: In whole-pattern internal mode, pulse A copies both buffers into the latch and pulse B has no effect.
- R8: In split internal mode, pulse A copies only the low buffer into latch bits 3..0 and pulse B copies only the high buffer into latch bits 5..4.
- R9: In external mode the selected edge of the external trigger copies both buffers. The other edge and both internal pulses have no effect.
- R10: When a buffer write and a transfer fall on the same clock edge, the latch takes the old buffer value and the new value waits for the next transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for writes and reads |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register (combinational) |
| trig_a | input | 1 | Internal trigger pulse A |
| trig_b | input | 1 | Internal trigger pulse B |
| ext_trig | input | 1 | External trigger level, edge detected |
| pins | output | 6 | Pattern outputs |

## Verification
Register writes and internal trigger pulses take effect at the clock edge that samples them. The pins then follow combinationally, so a result is due one edge after the stimulus. An external edge is seen when the new level is sampled against the level registered at the previous edge, so it also lands on that first edge. Read data is combinational and is sampled one time step after the address settles. The bench drives every stimulus on a falling clock edge and samples on the following falling edge. Each result is therefore read half a cycle after the rising edge that was due to produce it.

// File: rtl/rto_pkg.sv
package rto_pkg;
  typedef enum logic [1:0] {
    REG_BUFLO = 2'd0,
    REG_BUFHI = 2'd1,
    REG_SEL   = 2'd2,
    REG_CTRL  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic oe;
    logic ext_sel;
    logic split;
    logic edge_fall;
  } ctrl_t;

  localparam int CFG_EDGE_BIT  = 0;
  localparam int CFG_SPLIT_BIT = 1;
  localparam int CFG_EXT_BIT   = 2;
endpackage

// File: rtl/rto_regs.sv
module rto_regs
  import rto_pkg::*;
#(
  parameter int LO_W = 4,
  parameter int HI_W = 2,
  parameter int DW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           addr,
  input  logic [DW-1:0]        wr_data,
  output logic [DW-1:0]        rd_data,
  output logic [LO_W-1:0]      buf_lo,
  output logic [HI_W-1:0]      buf_hi,
  output logic [LO_W+HI_W-1:0] sel,
  output ctrl_t                ctrl,
  output logic                 pend_any
);
  localparam int OUT_W  = LO_W + HI_W;
  localparam int OE_BIT = DW - 1;

  logic [LO_W-1:0]  lo_q, lo_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic [OUT_W-1:0] sel_q, sel_d;
  ctrl_t            ctrl_q, ctrl_d;
  logic             pend_lo_q, pend_lo_d;
  logic             pend_hi_q, pend_hi_d;
  logic             unused_wdata;

  assign unused_wdata = ^wr_data;

  always_comb begin
    lo_d      = lo_q;
    hi_d      = hi_q;
    sel_d     = sel_q;
    ctrl_d    = ctrl_q;
    pend_lo_d = pend_lo_q;
    pend_hi_d = pend_hi_q;
    if (wr_en) begin
      case (reg_addr_e'(addr))
        REG_BUFLO: begin
          lo_d      = wr_data[LO_W-1:0];
          pend_lo_d = 1'b0;
        end
        REG_BUFHI: begin
          hi_d      = wr_data[HI_W-1:0];
          pend_hi_d = 1'b0;
        end
        REG_SEL: sel_d = wr_data[OUT_W-1:0];
        REG_CTRL: begin
          ctrl_d.oe = wr_data[OE_BIT];
          if (!ctrl_q.oe) begin
            ctrl_d.ext_sel   = wr_data[CFG_EXT_BIT];
            ctrl_d.split     = wr_data[CFG_SPLIT_BIT];
            ctrl_d.edge_fall = wr_data[CFG_EDGE_BIT];
          end
        end
        default: ;
      endcase
    end
    if (ctrl_q.oe && !ctrl_d.oe) begin
      pend_lo_d = 1'b1;
      pend_hi_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q      <= '0;
      hi_q      <= '0;
      sel_q     <= '0;
      ctrl_q    <= '0;
      pend_lo_q <= 1'b0;
      pend_hi_q <= 1'b0;
    end else begin
      lo_q      <= lo_d;
      hi_q      <= hi_d;
      sel_q     <= sel_d;
      ctrl_q    <= ctrl_d;
      pend_lo_q <= pend_lo_d;
      pend_hi_q <= pend_hi_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_addr_e'(addr))
      REG_BUFLO: rd_data[LO_W-1:0]  = lo_q;
      REG_BUFHI: rd_data[HI_W-1:0]  = hi_q;
      REG_SEL:   rd_data[OUT_W-1:0] = sel_q;
      REG_CTRL: begin
        rd_data[OE_BIT]        = ctrl_q.oe;
        rd_data[CFG_EXT_BIT]   = ctrl_q.ext_sel;
        rd_data[CFG_SPLIT_BIT] = ctrl_q.split;
        rd_data[CFG_EDGE_BIT]  = ctrl_q.edge_fall;
      end
      default: ;
    endcase
  end

  assign buf_lo   = lo_q;
  assign buf_hi   = hi_q;
  assign sel      = sel_q;
  assign ctrl     = ctrl_q;
  assign pend_any = pend_lo_q | pend_hi_q;
endmodule

// File: rtl/rto_trigger.sv
module rto_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_a,
  input  logic trig_b,
  input  logic ext_trig,
  input  logic ext_sel,
  input  logic split,
  input  logic edge_fall,
  output logic load_lo,
  output logic load_hi
);
  logic ext_q, ext_d;
  logic rise, fall, ext_evt;

  assign ext_d = ext_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_d;
  end

  assign rise    = ext_trig & ~ext_q;
  assign fall    = ~ext_trig & ext_q;
  assign ext_evt = edge_fall ? fall : rise;

  always_comb begin
    if (ext_sel) begin
      load_lo = ext_evt;
      load_hi = ext_evt;
    end else if (split) begin
      load_lo = trig_a;
      load_hi = trig_b;
    end else begin
      load_lo = trig_a;
      load_hi = trig_a;
    end
  end
endmodule

// File: rtl/rto_outlatch.sv
module rto_outlatch #(
  parameter int LO_W = 4,
  parameter int HI_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_lo,
  input  logic                 load_hi,
  input  logic [LO_W-1:0]      buf_lo,
  input  logic [HI_W-1:0]      buf_hi,
  input  logic [LO_W+HI_W-1:0] sel,
  input  logic                 oe,
  input  logic                 pend_any,
  output logic [LO_W+HI_W-1:0] latch,
  output logic [LO_W+HI_W-1:0] pins
);
  localparam int OUT_W = LO_W + HI_W;

  logic [LO_W-1:0] lat_lo_q, lat_lo_d;
  logic [HI_W-1:0] lat_hi_q, lat_hi_d;
  logic            drive;

  always_comb begin
    lat_lo_d = load_lo ? buf_lo : lat_lo_q;
    lat_hi_d = load_hi ? buf_hi : lat_hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_lo_q <= '0;
      lat_hi_q <= '0;
    end else begin
      lat_lo_q <= lat_lo_d;
      lat_hi_q <= lat_hi_d;
    end
  end

  assign latch = {lat_hi_q, lat_lo_q};
  assign drive = oe & ~pend_any;

  for (genvar i = 0; i < OUT_W; i++) begin : g_pin
    assign pins[i] = drive & sel[i] & latch[i];
  end
endmodule

// File: rtl/trig_outport.sv
module trig_outport
  import rto_pkg::*;
#(
  parameter int LO_W = 4,
  parameter int HI_W = 2,
  parameter int DW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           addr,
  input  logic [DW-1:0]        wr_data,
  output logic [DW-1:0]        rd_data,
  input  logic                 trig_a,
  input  logic                 trig_b,
  input  logic                 ext_trig,
  output logic [LO_W+HI_W-1:0] pins
);
  localparam int OUT_W = LO_W + HI_W;

  logic [1:0]       rst_pipe;
  logic             rst_sync;
  logic [LO_W-1:0]  buf_lo;
  logic [HI_W-1:0]  buf_hi;
  logic [OUT_W-1:0] sel;
  ctrl_t            ctrl;
  logic             pend_any;
  logic             load_lo, load_hi;
  logic [OUT_W-1:0] latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync = rst_pipe[1];

  rto_regs #(.LO_W(LO_W), .HI_W(HI_W), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .buf_lo   (buf_lo),
    .buf_hi   (buf_hi),
    .sel      (sel),
    .ctrl     (ctrl),
    .pend_any (pend_any)
  );

  rto_trigger u_trig (
    .clk       (clk),
    .rst_n     (rst_sync),
    .trig_a    (trig_a),
    .trig_b    (trig_b),
    .ext_trig  (ext_trig),
    .ext_sel   (ctrl.ext_sel),
    .split     (ctrl.split),
    .edge_fall (ctrl.edge_fall),
    .load_lo   (load_lo),
    .load_hi   (load_hi)
  );

  rto_outlatch #(.LO_W(LO_W), .HI_W(HI_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_sync),
    .load_lo  (load_lo),
    .load_hi  (load_hi),
    .buf_lo   (buf_lo),
    .buf_hi   (buf_hi),
    .sel      (sel),
    .oe       (ctrl.oe),
    .pend_any (pend_any),
    .latch    (latch),
    .pins     (pins)
  );
endmodule

// File: rtl/trig_outport_chk.sv
module trig_outport_chk #(
  parameter int OUT_W = 6,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oe,
  input logic [2:0]       cfg,
  input logic             pend_any,
  input logic [OUT_W-1:0] sel,
  input logic             load_lo,
  input logic             load_hi,
  input logic [OUT_W-1:0] latch,
  input logic [OUT_W-1:0] pins,
  input logic [1:0]       addr,
  input logic [DW-1:0]    rd_data
);
  assert_off_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> pins == '0);

  assert_unselected_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pins & ~sel) == '0);

  assert_pins_from_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pins & ~latch) == '0);

  assert_cfg_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    oe |=> cfg == $past(cfg));

  assert_hi_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 2'd1 |-> rd_data[DW-1:2] == '0);

  assert_rewrite_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any |-> pins == '0);

  assert_disable_sets_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> pend_any);

  assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_lo || load_hi) |=> $stable(latch));
endmodule

bind trig_outport trig_outport_chk #(.OUT_W(LO_W + HI_W), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync),
  .oe       (ctrl.oe),
  .cfg      ({ctrl.ext_sel, ctrl.split, ctrl.edge_fall}),
  .pend_any (pend_any),
  .sel      (sel),
  .load_lo  (load_lo),
  .load_hi  (load_hi),
  .latch    (latch),
  .pins     (pins),
  .addr     (addr),
  .rd_data  (rd_data)
);

// File: tb/test_trig_outport.sv
module test_trig_outport;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       trig_a, trig_b, ext_trig;
  logic [5:0] pins;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  trig_outport i_trig_outport (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .trig_a(trig_a), .trig_b(trig_b), .ext_trig(ext_trig),
    .pins(pins)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic a, input logic b);
    @(negedge clk);
    trig_a = a; trig_b = b;
    @(negedge clk);
    trig_a = 1'b0; trig_b = 1'b0;
  endtask

  task automatic set_ext(input logic v);
    @(negedge clk);
    ext_trig = v;
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 pins", {2'b0, pins}, 8'h00);
    for (int i = 0; i < 4; i++) begin
      rd(i[1:0], v);
      chk("R1 readback", v, 8'h00);
    end
  endtask

  task automatic t_enable_gate;
    logic [7:0] v;
    wr(2'd2, 8'h3F);
    wr(2'd0, 8'h0A);
    wr(2'd1, 8'h03);
    pulse(1'b1, 1'b0);
    chk("R2 disabled pins", {2'b0, pins}, 8'h00);
    wr(2'd3, 8'h80);
    chk("R3 enabled pins", {2'b0, pins}, 8'h3A);
    wr(2'd2, 8'h0F);
    chk("R3 partial select", {2'b0, pins}, 8'h0A);
    rd(2'd2, v);
    chk("R3 select readback", v, 8'h0F);
    wr(2'd2, 8'h3F);
  endtask

  task automatic t_whole;
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h01);
    chk("R7 no trigger", {2'b0, pins}, 8'h3A);
    pulse(1'b0, 1'b1);
    chk("R7 pulse B ignored", {2'b0, pins}, 8'h3A);
    pulse(1'b1, 1'b0);
    chk("R7 pulse A loads", {2'b0, pins}, 8'h15);
  endtask

  task automatic t_lock;
    logic [7:0] v;
    wr(2'd3, 8'h87);
    rd(2'd3, v);
    chk("R4 setup locked", v, 8'h80);
    wr(2'd3, 8'h00);
    chk("R2 off again", {2'b0, pins}, 8'h00);
    wr(2'd3, 8'h02);
    rd(2'd3, v);
    chk("R4 setup written", v, 8'h02);
  endtask

  task automatic t_rewrite;
    wr(2'd3, 8'h82);
    chk("R6 pending after enable", {2'b0, pins}, 8'h00);
    wr(2'd0, 8'h0C);
    chk("R6 only low rewritten", {2'b0, pins}, 8'h00);
    wr(2'd1, 8'h02);
    chk("R6 both rewritten", {2'b0, pins}, 8'h15);
  endtask

  task automatic t_split;
    pulse(1'b1, 1'b0);
    chk("R8 pulse A low only", {2'b0, pins}, 8'h1C);
    pulse(1'b0, 1'b1);
    chk("R8 pulse B high only", {2'b0, pins}, 8'h2C);
  endtask

  task automatic t_ext;
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h04);
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h01);
    wr(2'd3, 8'h84);
    chk("R9 enabled no edge", {2'b0, pins}, 8'h2C);
    pulse(1'b1, 1'b1);
    chk("R9 internal ignored", {2'b0, pins}, 8'h2C);
    set_ext(1'b1);
    chk("R9 rising loads", {2'b0, pins}, 8'h13);
    wr(2'd0, 8'h07);
    set_ext(1'b0);
    chk("R9 falling ignored", {2'b0, pins}, 8'h13);
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h05);
    wr(2'd0, 8'h07);
    wr(2'd1, 8'h01);
    wr(2'd3, 8'h85);
    set_ext(1'b1);
    chk("R9 rising ignored in fall mode", {2'b0, pins}, 8'h13);
    wr(2'd0, 8'h0E);
    set_ext(1'b0);
    chk("R9 falling loads", {2'b0, pins}, 8'h1E);
  endtask

  task automatic t_hi_mask;
    logic [7:0] v;
    wr(2'd1, 8'hFF);
    rd(2'd1, v);
    chk("R5 high buffer mask", v, 8'h03);
  endtask

  task automatic t_same_edge;
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h80);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h00);
    chk("R6 rewrite then latch", {2'b0, pins}, 8'h1E);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wr_data = 8'h06; trig_a = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; trig_a = 1'b0;
    chk("R10 old value moved", {2'b0, pins}, 8'h01);
    pulse(1'b1, 1'b0);
    chk("R10 new value next", {2'b0, pins}, 8'h06);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0; wr_data = 8'h00;
    trig_a = 1'b0; trig_b = 1'b0; ext_trig = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_enable_gate();
    t_whole();
    t_lock();
    t_rewrite();
    t_split();
    t_ext();
    t_hi_mask();
    t_same_edge();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule